// File: doc/BRIEF.md
# Distributed Vector Sum Combiner

This block forms the complex vector sum of cavity-field samples when the channels are split across two boards. Each board receives signed 16-bit in-phase and quadrature samples for its own group of channels, together with a strobe that marks a new sample. The logic clock runs at twice the sample rate, so the strobe is normally high on every other cycle. On a board set as a slave, the block adds the enabled channels into a widened partial sum. It then sends that sum once per sample as a single framed link word.

On a board set as the master, the block forms its own local partial sum in the same way. That sum passes through a delay line that can be set from 0 to 63 sample periods, so that it lines up with the partial sum that arrives late over the link. The block then adds the delayed local sum to the most recent good remote sum. It saturates the result to 18 bits and presents it with a valid strobe. A post-sum filter or a feedback controller can use this result.

A received frame whose marker field is wrong raises a link-error flag. While that flag is set, the total keeps its last good value.

Top module: `vsum_combiner`

## Requirements
- R1: One registered stage after a sample strobe, the partial sum holds the signed sum of the I samples, and separately of the Q samples, of every enabled channel. It is carried at 16 + clog2(channels+1) bits (19 bits by default), so no overflow occurs.
- R2: A channel whose bit in `ch_en` is 0 adds nothing to either partial sum, whatever its sample values.
- R3: In slave mode, `tx_valid` pulses on the second clock edge after the edge that takes the strobe. `tx_word` then holds marker 0xA5 in its top 8 bits, the I partial sum in the next 19 bits and the Q partial sum in the low 19 bits, both in two's complement. `tot_valid` stays low.
- R4: In master mode, `tot_valid` pulses on the second clock edge after the strobe edge. `tot_i`/`tot_q` then equal the delayed local partial sum plus the remote partial sum from the last good frame received up to and including the strobe edge.
- R5: With delay setting d, the local operand for sample k is the local partial sum of sample k−d. d=0 uses the current sample. d=63 is the largest setting. Samples from before reset count as zero.
- R6: `dly_set` is taken only on an edge where `smp_valid` is high, and it applies to that sample and to later ones. Changes while the strobe is low have no effect until the next strobe.
- R7: The total is saturated to 18-bit signed: sums above 131071 give 131071, and sums below −131072 give −131072.
- R8: A frame with `rx_valid` high and a marker other than 0xA5 sets `link_err` on the next edge. The remote operand is not updated. While `link_err` is high, totals are neither updated nor flagged valid. The next good frame clears `link_err`.
- R9: After reset, all outputs are zero, and the delay line reads as zero.
- R10: In master mode, `tx_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1 = master (combine), 0 = slave (transmit partial sum) |
| smp_valid | input | 1 | New input sample strobe |
| ch_i | input | N_CH*16 | Per-channel signed I samples, channel c at bits [16c+15:16c] |
| ch_q | input | N_CH*16 | Per-channel signed Q samples |
| ch_en | input | N_CH | Channel enable mask |
| dly_set | input | 6 | Local delay in sample periods |
| rx_valid | input | 1 | Received link word strobe |
| rx_word | input | 46 | Received frame: marker, I, Q |
| tot_valid | output | 1 | Total vector sum valid pulse |
| tot_i | output | 18 | Saturated total I |
| tot_q | output | 18 | Saturated total Q |
| link_err | output | 1 | Last received frame had a bad marker |
| tx_valid | output | 1 | Transmit frame valid pulse |
| tx_word | output | 46 | Transmit frame: marker, I, Q |

## Verification
The hardest situation to reach is a long link latency matched by the delay line. Here the remote operand of sample k belongs to an earlier instant, and it must meet the local sum of that same instant that has been stored for up to 63 samples. The bench plays the role of the slave. It sends frames that carry partial sums lagged by a fixed number of samples, sets the matching delay, and compares each total with a reference built from its own history of time-aligned sums. This includes the 63-sample limit, where the delay line wraps. A separate scenario changes the delay setting in the cycle after a strobe, to show that the setting is sampled at the boundary.

// File: rtl/vsum_pkg.sv
package vsum_pkg;

  localparam int MARK_W = 8;
  localparam logic [MARK_W-1:0] FRAME_MARK = 8'hA5;

  // width that holds the sum of n signed dw-bit values
  function automatic int sum_width(input int dw, input int n);
    return dw + $clog2(n + 1);
  endfunction

  // clip a signed value into the range of an ow-bit signed number
  function automatic logic signed [31:0] clip(input logic signed [31:0] v, input int ow);
    logic signed [31:0] hi;
    logic signed [31:0] lo;
    hi = (32'sd1 <<< (ow - 1)) - 32'sd1;
    lo = -hi - 32'sd1;
    if (v > hi)      return hi;
    else if (v < lo) return lo;
    else             return v;
  endfunction

endpackage

// File: rtl/vsum_partial.sv
module vsum_partial #(
  parameter int N_CH = 4,
  parameter int DW   = 16,
  parameter int SW   = 19
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        smp_valid,
  input  logic [N_CH*DW-1:0]          ch_i,
  input  logic [N_CH*DW-1:0]          ch_q,
  input  logic [N_CH-1:0]             ch_en,
  output logic signed [SW-1:0]        psum_i,
  output logic signed [SW-1:0]        psum_q,
  output logic                        ps_vld
);

  logic signed [SW-1:0] ext_i [N_CH];
  logic signed [SW-1:0] ext_q [N_CH];
  logic signed [SW-1:0] acc_i;
  logic signed [SW-1:0] acc_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_ext
    assign ext_i[c] = SW'(signed'(ch_i[c*DW +: DW]));
    assign ext_q[c] = SW'(signed'(ch_q[c*DW +: DW]));
  end

  always_comb begin
    acc_i = '0;
    acc_q = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (ch_en[c]) begin
        acc_i = acc_i + ext_i[c];
        acc_q = acc_q + ext_q[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psum_i <= '0;
      psum_q <= '0;
      ps_vld <= 1'b0;
    end else begin
      ps_vld <= smp_valid;
      if (smp_valid) begin
        psum_i <= acc_i;
        psum_q <= acc_q;
      end
    end
  end

  // R1: a partial sum is only flagged one edge after a strobe
  p_psum_follows_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ps_vld |-> $past(smp_valid));

endmodule

// File: rtl/vsum_delay.sv
module vsum_delay #(
  parameter int SW = 19,
  parameter int AW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic signed [SW-1:0] din_i,
  input  logic signed [SW-1:0] din_q,
  input  logic [AW-1:0]        dly,
  output logic signed [SW-1:0] dout_i,
  output logic signed [SW-1:0] dout_q
);

  localparam int DEPTH = 1 << AW;

  logic signed [SW-1:0] mem_i [DEPTH];
  logic signed [SW-1:0] mem_q [DEPTH];
  logic [AW-1:0]        wp;
  logic [AW-1:0]        rd_idx;
  logic                 bypass;

  assign rd_idx = wp - dly;
  assign bypass = (dly == '0);

  always_comb begin
    if (bypass) begin
      dout_i = din_i;
      dout_q = din_q;
    end else begin
      dout_i = mem_i[rd_idx];
      dout_q = mem_q[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        mem_i[k] <= '0;
        mem_q[k] <= '0;
      end
    end else if (wr_en) begin
      mem_i[wp] <= din_i;
      mem_q[wp] <= din_q;
      wp        <= wp + 1'b1;
    end
  end

endmodule

// File: rtl/vsum_link_rx.sv
module vsum_link_rx #(
  parameter int SW = 19,
  parameter int FW = 46
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_valid,
  input  logic [FW-1:0]        rx_word,
  output logic signed [SW-1:0] rem_i,
  output logic signed [SW-1:0] rem_q,
  output logic                 err
);

  import vsum_pkg::*;

  logic [MARK_W-1:0] mark_f;
  logic              mark_ok;

  assign mark_f  = rx_word[FW-1 -: MARK_W];
  assign mark_ok = (mark_f == FRAME_MARK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_i <= '0;
      rem_q <= '0;
      err   <= 1'b0;
    end else if (rx_valid) begin
      if (mark_ok) begin
        rem_i <= signed'(rx_word[2*SW-1:SW]);
        rem_q <= signed'(rx_word[SW-1:0]);
        err   <= 1'b0;
      end else begin
        err   <= 1'b1;
      end
    end
  end

  // R8: a bad marker raises the error flag on the next edge
  p_bad_marker_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && (rx_word[FW-1 -: MARK_W] != FRAME_MARK)) |=> err);

endmodule

// File: rtl/vsum_combiner.sv
module vsum_combiner #(
  parameter int N_CH  = 4,
  parameter int DW    = 16,
  parameter int DLY_W = 6,
  parameter int OW    = 18,
  localparam int SW   = vsum_pkg::sum_width(DW, N_CH),
  localparam int FW   = vsum_pkg::MARK_W + 2*SW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 is_master,
  input  logic                 smp_valid,
  input  logic [N_CH*DW-1:0]   ch_i,
  input  logic [N_CH*DW-1:0]   ch_q,
  input  logic [N_CH-1:0]      ch_en,
  input  logic [DLY_W-1:0]     dly_set,
  input  logic                 rx_valid,
  input  logic [FW-1:0]        rx_word,
  output logic                 tot_valid,
  output logic signed [OW-1:0] tot_i,
  output logic signed [OW-1:0] tot_q,
  output logic                 link_err,
  output logic                 tx_valid,
  output logic [FW-1:0]        tx_word
);

  import vsum_pkg::*;

  localparam int TW = SW + 1;

  logic signed [SW-1:0] psum_i, psum_q;
  logic                 ps_vld;
  logic signed [SW-1:0] del_i, del_q;
  logic signed [SW-1:0] rem_i, rem_q;
  logic                 err_q;
  logic [DLY_W-1:0]     dly_act;
  logic signed [TW-1:0] sum_i, sum_q;
  logic                 comb_fire;
  logic                 comb_take;
  logic                 send_fire;

  always_ff @(posedge clk) begin
    if (!rst_n)         dly_act <= '0;
    else if (smp_valid) dly_act <= dly_set;
  end

  // R6: setting only moves on a sample boundary
  p_dly_on_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(dly_act));

  vsum_partial #(.N_CH(N_CH), .DW(DW), .SW(SW)) u_part (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .ch_i(ch_i), .ch_q(ch_q), .ch_en(ch_en),
    .psum_i(psum_i), .psum_q(psum_q), .ps_vld(ps_vld)
  );

  vsum_delay #(.SW(SW), .AW(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .wr_en(ps_vld),
    .din_i(psum_i), .din_q(psum_q), .dly(dly_act),
    .dout_i(del_i), .dout_q(del_q)
  );

  vsum_link_rx #(.SW(SW), .FW(FW)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
    .rem_i(rem_i), .rem_q(rem_q), .err(err_q)
  );

  assign sum_i     = TW'(del_i) + TW'(rem_i);
  assign sum_q     = TW'(del_q) + TW'(rem_q);
  assign comb_fire = ps_vld && is_master;
  assign comb_take = comb_fire && !err_q;
  assign send_fire = ps_vld && !is_master;
  assign link_err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tot_valid <= 1'b0;
      tot_i     <= '0;
      tot_q     <= '0;
    end else begin
      tot_valid <= comb_take;
      if (comb_take) begin
        tot_i <= OW'(clip(32'(sum_i), OW));
        tot_q <= OW'(clip(32'(sum_q), OW));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_word  <= '0;
    end else begin
      tx_valid <= send_fire;
      if (send_fire) tx_word <= {FRAME_MARK, psum_i, psum_q};
    end
  end

  // R8: while the link is in error the total is frozen and not flagged
  p_hold_on_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> ($stable(tot_i) && $stable(tot_q) && !tot_valid));

  // R10: frames leave only from a board that was in slave mode
  p_tx_only_slave_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(!is_master));

endmodule

// File: tb/vsum_combiner_test.sv
module vsum_combiner_test;

  localparam int N_CH  = 4;
  localparam int DW    = 16;
  localparam int DLY_W = 6;
  localparam int OW    = 18;
  localparam int SW    = DW + $clog2(N_CH + 1);
  localparam int FW    = 8 + 2*SW;
  localparam logic [7:0] MK = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                 is_master = 1'b0;
  logic                 smp_valid = 1'b0;
  logic [N_CH*DW-1:0]   ch_i = '0;
  logic [N_CH*DW-1:0]   ch_q = '0;
  logic [N_CH-1:0]      ch_en = '1;
  logic [DLY_W-1:0]     dly_set = '0;
  logic                 rx_valid = 1'b0;
  logic [FW-1:0]        rx_word = '0;
  logic                 tot_valid;
  logic signed [OW-1:0] tot_i, tot_q;
  logic                 link_err;
  logic                 tx_valid;
  logic [FW-1:0]        tx_word;

  vsum_combiner uut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .smp_valid(smp_valid),
    .ch_i(ch_i), .ch_q(ch_q), .ch_en(ch_en), .dly_set(dly_set),
    .rx_valid(rx_valid), .rx_word(rx_word), .tot_valid(tot_valid),
    .tot_i(tot_i), .tot_q(tot_q), .link_err(link_err),
    .tx_valid(tx_valid), .tx_word(tx_word)
  );

  int n_run = 0;
  int n_fail = 0;
  int li [N_CH];
  int lq [N_CH];
  int loc_i [256];
  int loc_q [256];
  int rem_hi [256];
  int rem_hq [256];
  int nsmp = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat18(input int v);
    int top;
    top = (1 << (OW - 1)) - 1;
    if (v > top) return top;
    if (v < -top - 1) return -top - 1;
    return v;
  endfunction

  function automatic logic [FW-1:0] frame(input logic [7:0] m, input int fi, input int fq);
    logic [SW-1:0] a;
    logic [SW-1:0] b;
    a = SW'(fi);
    b = SW'(fq);
    return {m, a, b};
  endfunction

  function automatic int past_i(input int k, input int d);
    if (k - d < 0) return 0;
    return loc_i[(k - d) % 256];
  endfunction

  function automatic int past_q(input int k, input int d);
    if (k - d < 0) return 0;
    return loc_q[(k - d) % 256];
  endfunction

  task automatic pattern(input int s);
    for (int c = 0; c < N_CH; c++) begin
      li[c] = ((s * 7919 + c * 3301) % 60001) - 30000;
      lq[c] = ((s * 4421 + c * 1777 + 9000) % 60001) - 30000;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    smp_valid = 1'b0;
    rx_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    nsmp = 0;
  endtask

  // one sample: strobe, then outputs of that sample are visible at the return
  task automatic run_sample(input bit rxv, input logic [FW-1:0] frm,
                            input int d_now, input int d_after);
    int si;
    int sq;
    @(negedge clk);
    si = 0;
    sq = 0;
    for (int c = 0; c < N_CH; c++) begin
      ch_i[c*DW +: DW] = DW'(li[c]);
      ch_q[c*DW +: DW] = DW'(lq[c]);
      if (ch_en[c]) begin
        si += li[c];
        sq += lq[c];
      end
    end
    loc_i[nsmp % 256] = si;
    loc_q[nsmp % 256] = sq;
    nsmp++;
    dly_set   = DLY_W'(d_now);
    smp_valid = 1'b1;
    rx_valid  = rxv;
    rx_word   = frm;
    @(negedge clk);
    smp_valid = 1'b0;
    rx_valid  = 1'b0;
    dly_set   = DLY_W'(d_after);
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9", "tot_valid", tot_valid, 0);
    chk("R9", "tot_i", tot_i, 0);
    chk("R9", "tot_q", tot_q, 0);
    chk("R9", "tx_valid", tx_valid, 0);
    chk("R9", "link_err", link_err, 0);
  endtask

  task automatic t_slave();
    is_master = 1'b0;
    ch_en = '1;
    do_reset();
    for (int s = 0; s < 6; s++) begin
      if (s >= 3) ch_en = 4'b0101;
      pattern(s + 3);
      run_sample(1'b0, '0, 0, 0);
      chk("R3", "tx_valid", tx_valid, 1);
      chk("R3", "marker", tx_word[FW-1 -: 8], MK);
      chk(s >= 3 ? "R2" : "R1", "tx I", int'($signed(tx_word[2*SW-1:SW])), loc_i[s]);
      chk(s >= 3 ? "R2" : "R1", "tx Q", int'($signed(tx_word[SW-1:0])), loc_q[s]);
      chk("R3", "tot_valid in slave", tot_valid, 0);
      @(negedge clk);
      chk("R3", "tx_valid one pulse", tx_valid, 0);
    end
    ch_en = '1;
  endtask

  task automatic t_master_zero();
    is_master = 1'b1;
    do_reset();
    for (int s = 0; s < 4; s++) begin
      int ri;
      int rq;
      pattern(s + 40);
      ri = s * 1000 - 1500;
      rq = 2000 - s * 700;
      run_sample(1'b1, frame(MK, ri, rq), 0, 0);
      chk("R4", "tot_valid", tot_valid, 1);
      chk("R5", "tot_i d=0", tot_i, sat18(loc_i[s] + ri));
      chk("R4", "tot_q d=0", tot_q, sat18(loc_q[s] + rq));
      chk("R10", "tx_valid in master", tx_valid, 0);
    end
  endtask

  // remote frames lag by lat samples; matching delay aligns both operands
  task automatic t_latency(input int lat, input int count, input int first_chk);
    is_master = 1'b1;
    do_reset();
    for (int k = 0; k < count; k++) begin
      int fi;
      int fq;
      pattern(k + 100);
      rem_hi[k % 256] = ((k * 523) % 20000) - 10000;
      rem_hq[k % 256] = ((k * 811) % 20000) - 10000;
      fi = (k >= lat) ? rem_hi[(k - lat) % 256] : 0;
      fq = (k >= lat) ? rem_hq[(k - lat) % 256] : 0;
      run_sample(1'b1, frame(MK, fi, fq), lat, lat);
      if (k >= first_chk) begin
        chk("R5", "aligned I", tot_i, sat18(past_i(k, lat) + fi));
        chk("R4", "aligned Q", tot_q, sat18(past_q(k, lat) + fq));
      end
    end
  endtask

  task automatic t_boundary();
    is_master = 1'b1;
    do_reset();
    for (int k = 0; k < 4; k++) begin
      pattern(k + 200);
      run_sample(1'b1, frame(MK, 0, 0), 0, 0);
    end
    pattern(204);
    run_sample(1'b1, frame(MK, 11, -7), 2, 7);
    chk("R6", "setting taken with strobe I", tot_i, sat18(past_i(4, 2) + 11));
    chk("R6", "setting taken with strobe Q", tot_q, sat18(past_q(4, 2) - 7));
    pattern(205);
    run_sample(1'b1, frame(MK, 5, 6), 7, 7);
    chk("R6", "new setting next sample I", tot_i, 5);
    chk("R9", "unwritten slot reads zero Q", tot_q, 6);
  endtask

  task automatic t_saturate();
    is_master = 1'b1;
    do_reset();
    for (int c = 0; c < N_CH; c++) begin
      li[c] = 32767;
      lq[c] = -32768;
    end
    run_sample(1'b1, frame(MK, 131068, -131072), 0, 0);
    chk("R7", "positive clip", tot_i, 131071);
    chk("R7", "negative clip", tot_q, -131072);
    for (int c = 0; c < N_CH; c++) begin
      li[c] = 30000;
      lq[c] = -30000;
    end
    run_sample(1'b1, frame(MK, 11071, -11072), 0, 0);
    chk("R7", "edge in range I", tot_i, 131071);
    chk("R7", "edge in range Q", tot_q, -131072);
  endtask

  task automatic t_link_err();
    int held_i;
    int held_q;
    is_master = 1'b1;
    do_reset();
    pattern(300);
    run_sample(1'b1, frame(MK, 100, 200), 0, 0);
    held_i = tot_i;
    held_q = tot_q;
    chk("R4", "good before error", held_i, sat18(loc_i[0] + 100));
    pattern(301);
    run_sample(1'b1, frame(8'h5A, 9999, 9999), 0, 0);
    chk("R8", "link_err set", link_err, 1);
    chk("R8", "tot_valid suppressed", tot_valid, 0);
    chk("R8", "tot_i held", tot_i, held_i);
    chk("R8", "tot_q held", tot_q, held_q);
    pattern(302);
    run_sample(1'b1, frame(MK, -50, 60), 0, 0);
    chk("R8", "link_err cleared", link_err, 0);
    chk("R8", "tot_valid back", tot_valid, 1);
    chk("R8", "new total I", tot_i, sat18(loc_i[2] - 50));
    chk("R8", "new total Q", tot_q, sat18(loc_q[2] + 60));
  endtask

  initial begin
    t_reset();
    t_slave();
    t_master_zero();
    t_latency(5, 24, 0);
    t_latency(63, 68, 60);
    t_boundary();
    t_saturate();
    t_link_err();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule